// File: doc/BRIEF.md
# Accumulator Word-Machine Execution Core

This block executes one instruction of a 16-bit accumulator machine each time it is started. It holds a 16-bit accumulator, a one-bit link flag and an instruction pointer. It reaches a synchronous, word-addressed memory through address, write-data, write-enable and read-data ports, where read data arrives one clock after the address. A one-cycle start pulse makes the core do three things in turn: fetch the word at the instruction pointer, decode it, and carry it out. It then raises a one-cycle completion pulse, together with the number of memory cycles the instruction is charged.

The instruction set covers a small group of operations:
- two immediate loads, one plain and one complemented;
- a jump;
- a store of the accumulator;
- an accumulator/memory swap;
- an increment-and-skip-on-zero;
- a two's-complement add.

Every memory-reference operation may name its operand through one level of pointer. While the core is idle, a load port can preset the accumulator, the link and the instruction pointer. A test environment can therefore set up the machine state, run one instruction and inspect the result.

Top module: `wm_core`

## Requirements
- R1: After reset the accumulator, link, instruction pointer, busy, done and cycle count are all zero.
- R2: A word whose bits 14..11 equal 0001 and whose bit 15 is 0 loads the accumulator with bits 7..0 zero-extended. It leaves the link unchanged, advances the pointer by one and is charged 1 cycle.
- R3: The same field with bit 15 set loads the bitwise complement of the zero-extended 8-bit value, so an operand of 0 gives 0177777 and an operand of 1 gives 0177776. The link is unchanged, the pointer advances by one and the cost is 1 cycle.
- R4: For the memory-reference fields (0010, 0100, 0101, 0110, 1101), bits 10..0 are the direct address. If bit 15 is set, the effective address is instead the low 11 bits of the word stored at the direct address, and only one level is followed. Indirection adds one cycle to the cost.
- R5: Field 0010 (jump) loads the pointer with the effective address at a cost of 2 cycles, or 3 when indirect. The accumulator and link are unchanged and nothing is written.
- R6: Field 0100 (store) writes the accumulator to the effective address. The pointer advances by one, the accumulator and link are unchanged, and the cost is 2 or 3 cycles.
- R7: Field 0101 (swap) writes the accumulator to the effective address and loads the accumulator with the old memory word. The pointer advances by one and the cost is 2 or 3 cycles.
- R8: Field 0110 (increment) writes the memory word plus one, modulo 2^16. The pointer advances by two when the result is zero and by one otherwise. The accumulator and link are unchanged and the cost is 2 or 3 cycles.
- R9: Field 1101 (add) sets the accumulator to the sum modulo 2^16 and inverts the link when the addition carries out of bit 15; without a carry the link keeps its value. The cost is 2 or 3 cycles.
- R10: Any other field value is a no-op. It writes nothing, leaves the accumulator and link as they were, advances the pointer by one and is charged 1 cycle.
- R11: While idle, the load strobe copies the load values into the accumulator, link and pointer, and they are visible on the next cycle. While an instruction is in progress, both the load strobe and the start input are ignored.
- R12: done is high for exactly one cycle, and in that cycle the registers already hold their new values and cycles holds the cost. When done is counted in clocks after the start pulse, it comes 3 clocks later for immediate, no-op and direct jump instructions. It comes 5 clocks later for an indirect jump and for other direct references, and 7 clocks later for other indirect references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Start one instruction (sampled when idle) |
| load_en | input | 1 | Preset strobe for accumulator, link and pointer (idle only) |
| load_ac | input | 16 | Accumulator preset value |
| load_link | input | 1 | Link preset value |
| load_pc | input | 11 | Instruction pointer preset value |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| ac | output | 16 | Accumulator |
| link | output | 1 | Link flag |
| pc | output | 11 | Instruction pointer |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 2 | Cost of the last completed instruction |

## Verification
Results are due a fixed number of clocks after the start pulse. That number is 3 for immediate, no-op and direct-jump words, 5 for an indirect jump or a direct operand reference, and 7 for an indirect operand reference. The bench derives this figure for each word it issues and counts falling edges from the start pulse to the done pulse, so any early or late result shows up as a latency mismatch. The accumulator, link, pointer, cost and the written memory word are all sampled on the falling edge where done is high. The preset is checked on the falling edge after its strobe. Each disturbed case also watches 10 further cycles to confirm that no second completion follows.

// File: rtl/wm_pkg.sv
// Shared types and field codes for the accumulator core.
// Assumes a 16-bit word with the operation field in bits 14..11.
package wm_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_NONE, OP_LDI, OP_JMP, OP_DEP, OP_XCH, OP_INC, OP_ADD
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_PTR_ADDR, ST_PTR_DATA, ST_OPND_ADDR, ST_EXEC
    } state_e;

    localparam logic [3:0] FLD_LDI = 4'b0001;
    localparam logic [3:0] FLD_JMP = 4'b0010;
    localparam logic [3:0] FLD_DEP = 4'b0100;
    localparam logic [3:0] FLD_XCH = 4'b0101;
    localparam logic [3:0] FLD_INC = 4'b0110;
    localparam logic [3:0] FLD_ADD = 4'b1101;
endpackage

// File: rtl/wm_decode.sv
// Instruction decoder: splits a word into operation, indirect flag,
// direct address, immediate value and the charged cycle cost.
// Assumes AW <= 11 so the address fits below the operation field.
module wm_decode #(
    parameter int AW = 11
) (
    input  logic [wm_pkg::WORD_W-1:0] word,
    output wm_pkg::op_e               op,
    output logic                      memref,
    output logic                      ind,
    output logic [AW-1:0]             addr,
    output logic [wm_pkg::WORD_W-1:0] imm_val,
    output logic [1:0]                cost
);
    import wm_pkg::*;
    localparam int IMM_W = 8;

    logic [3:0] fld;
    assign fld = word[14:11];

    // Map the operation field to an operation and classify it.
    always_comb begin
        case (fld)
            FLD_LDI: op = OP_LDI;
            FLD_JMP: op = OP_JMP;
            FLD_DEP: op = OP_DEP;
            FLD_XCH: op = OP_XCH;
            FLD_INC: op = OP_INC;
            FLD_ADD: op = OP_ADD;
            default: op = OP_NONE;
        endcase
        memref = (op != OP_NONE) && (op != OP_LDI);
        ind    = memref && word[WORD_W-1];
        addr   = word[AW-1:0];
    end

    // Immediate operand, complemented when the top bit is set.
    always_comb begin
        imm_val = {{(WORD_W-IMM_W){1'b0}}, word[IMM_W-1:0]};
        if (word[WORD_W-1]) imm_val = ~imm_val;
    end

    // Charged cost: 1 for register-only words, 2 plus one per indirection.
    always_comb begin
        if (!memref)   cost = 2'd1;
        else if (ind)  cost = 2'd3;
        else           cost = 2'd2;
    end
endmodule

// File: rtl/wm_alu.sv
// Operand arithmetic for the execute step: swap, add with link toggle,
// increment with zero detect and the store data selection.
// Assumes operand is the memory word read at the effective address.
module wm_alu #(
    parameter int W = 16
) (
    input  wm_pkg::op_e   op,
    input  logic [W-1:0]  ac,
    input  logic          link,
    input  logic [W-1:0]  operand,
    output logic [W-1:0]  new_ac,
    output logic          new_link,
    output logic [W-1:0]  wr_data,
    output logic          wr_en,
    output logic          inc_zero
);
    import wm_pkg::*;

    logic [W:0]   sum;
    logic [W-1:0] incr;

    // Arithmetic results shared by add and increment.
    always_comb begin
        sum  = {1'b0, ac} + {1'b0, operand};
        incr = operand + {{(W-1){1'b0}}, 1'b1};
    end

    // Select the register and memory results for the operation.
    always_comb begin
        new_ac   = ac;
        new_link = link;
        wr_data  = ac;
        wr_en    = 1'b0;
        case (op)
            OP_DEP: wr_en = 1'b1;
            OP_XCH: begin
                wr_en  = 1'b1;
                new_ac = operand;
            end
            OP_INC: begin
                wr_en   = 1'b1;
                wr_data = incr;
            end
            OP_ADD: begin
                new_ac   = sum[W-1:0];
                new_link = link ^ sum[W];
            end
            default: ;
        endcase
        inc_zero = (incr == '0);
    end
endmodule

// File: rtl/wm_seq.sv
// Instruction sequencer: walks fetch, decode, optional pointer read,
// operand read and execute, and flags the final step of each word.
// Assumes the decoded fields are valid in every non-idle state.
module wm_seq (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           memref,
    input  logic           ind,
    input  wm_pkg::op_e    op,
    output wm_pkg::state_e state,
    output logic           finish
);
    import wm_pkg::*;

    state_e nxt;

    // Next-state choice and end-of-instruction detection.
    always_comb begin
        nxt    = state;
        finish = 1'b0;
        case (state)
            ST_IDLE:   if (step) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (!memref) begin
                    nxt = ST_IDLE; finish = 1'b1;
                end else if (ind) begin
                    nxt = ST_PTR_ADDR;
                end else if (op == OP_JMP) begin
                    nxt = ST_IDLE; finish = 1'b1;
                end else begin
                    nxt = ST_OPND_ADDR;
                end
            end
            ST_PTR_ADDR: nxt = ST_PTR_DATA;
            ST_PTR_DATA: begin
                if (op == OP_JMP) begin
                    nxt = ST_IDLE; finish = 1'b1;
                end else begin
                    nxt = ST_OPND_ADDR;
                end
            end
            ST_OPND_ADDR: nxt = ST_EXEC;
            ST_EXEC: begin
                nxt = ST_IDLE; finish = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/wm_core.sv
// Multi-cycle accumulator core: runs one instruction per step pulse
// against a synchronous memory with one clock of read latency.
// Assumes memory returns data for the address presented on the prior edge.
module wm_core #(
    parameter int AW = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step,
    input  logic                      load_en,
    input  logic [wm_pkg::WORD_W-1:0] load_ac,
    input  logic                      load_link,
    input  logic [AW-1:0]             load_pc,
    output logic [AW-1:0]             mem_addr,
    output logic [wm_pkg::WORD_W-1:0] mem_wdata,
    output logic                      mem_we,
    input  logic [wm_pkg::WORD_W-1:0] mem_rdata,
    output logic [wm_pkg::WORD_W-1:0] ac,
    output logic                      link,
    output logic [AW-1:0]             pc,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                cycles
);
    import wm_pkg::*;
    localparam int W = WORD_W;
    localparam logic [AW-1:0] PC_ONE = AW'(1);
    localparam logic [AW-1:0] PC_TWO = AW'(2);

    state_e        state;
    logic          finish;
    logic [W-1:0]  ir;
    logic [AW-1:0] ea;
    logic [W-1:0]  dec_word;
    op_e           d_op;
    logic          d_memref, d_ind;
    logic [AW-1:0] d_addr;
    logic [W-1:0]  d_imm;
    logic [1:0]    d_cost;
    logic [W-1:0]  a_ac, a_wdata;
    logic          a_link, a_we, a_zero;

    // Decode the fresh memory word during decode, the held word afterwards.
    always_comb dec_word = (state == ST_DECODE) ? mem_rdata : ir;

    wm_decode #(.AW(AW)) u_dec (
        .word(dec_word), .op(d_op), .memref(d_memref), .ind(d_ind),
        .addr(d_addr), .imm_val(d_imm), .cost(d_cost)
    );

    wm_alu #(.W(W)) u_alu (
        .op(d_op), .ac(ac), .link(link), .operand(mem_rdata),
        .new_ac(a_ac), .new_link(a_link), .wr_data(a_wdata),
        .wr_en(a_we), .inc_zero(a_zero)
    );

    wm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .memref(d_memref),
        .ind(d_ind), .op(d_op), .state(state), .finish(finish)
    );

    // Memory port drive: pointer address on fetch, effective address otherwise.
    always_comb begin
        mem_addr  = (state == ST_FETCH || state == ST_IDLE) ? pc : ea;
        mem_we    = (state == ST_EXEC) && a_we;
        mem_wdata = a_wdata;
        busy      = (state != ST_IDLE);
    end

    // Architectural registers, instruction hold and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac     <= '0;
            link   <= 1'b0;
            pc     <= '0;
            ir     <= '0;
            ea     <= '0;
            done   <= 1'b0;
            cycles <= 2'd0;
        end else begin
            done <= finish;
            if (finish) cycles <= d_cost;
            case (state)
                ST_IDLE: begin
                    if (load_en) begin
                        ac   <= load_ac;
                        link <= load_link;
                        pc   <= load_pc;
                    end
                end
                ST_DECODE: begin
                    ir <= mem_rdata;
                    ea <= d_addr;
                    if (!d_memref) begin
                        pc <= pc + PC_ONE;
                        if (d_op == OP_LDI) ac <= d_imm;
                    end else if (!d_ind && d_op == OP_JMP) begin
                        pc <= d_addr;
                    end
                end
                ST_PTR_DATA: begin
                    ea <= mem_rdata[AW-1:0];
                    if (d_op == OP_JMP) pc <= mem_rdata[AW-1:0];
                end
                ST_EXEC: begin
                    ac   <= a_ac;
                    link <= a_link;
                    pc   <= (d_op == OP_INC && a_zero) ? pc + PC_TWO : pc + PC_ONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wm_core_chk.sv
// Property checker for wm_core, attached through bind.
// Assumes only the core's ports are observed.
module wm_core_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          load_en,
    input logic          mem_we,
    input logic [15:0]   ac,
    input logic          link,
    input logic [AW-1:0] pc,
    input logic          busy,
    input logic          done,
    input logic [1:0]    cycles
);
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_cost_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles != 2'd0));

    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy) |=> busy);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en) |=> ($stable(ac) && $stable(link) && $stable(pc)));

    assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind wm_core wm_core_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .load_en(load_en),
    .mem_we(mem_we), .ac(ac), .link(link), .pc(pc), .busy(busy),
    .done(done), .cycles(cycles)
);

// File: tb/tb_wm_core.sv
`timescale 1ns/1ps
module tb_wm_core;
    localparam int AW = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_ac = '0;
    logic        load_link = 1'b0;
    logic [AW-1:0] load_pc = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [15:0] ac;
    logic        link;
    logic [AW-1:0] pc;
    logic        busy, done;
    logic [1:0]  cycles;

    logic [15:0] mem [0:(1<<AW)-1];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    wm_core #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .step(step), .load_en(load_en),
        .load_ac(load_ac), .load_link(load_link), .load_pc(load_pc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .ac(ac), .link(link), .pc(pc),
        .busy(busy), .done(done), .cycles(cycles)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] fld, input bit hi);
        case (fld)
            4'b0001: return hi ? "R3" : "R2";
            4'b0010: return "R5";
            4'b0100: return "R6";
            4'b0101: return "R7";
            4'b0110: return "R8";
            4'b1101: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Run one word at pc0 from preset state and compare with bench model.
    task automatic run(input logic [15:0] instr, input logic [15:0] ac0,
                       input logic l0, input logic [AW-1:0] pc0, input bit disturb);
        logic [3:0]    fld;
        bit            mref, ind, wr, carry;
        logic [AW-1:0] dadr, eadr, e_pc;
        logic [15:0]   opnd, e_ac, wval, probe, s;
        logic          e_l;
        int            e_cyc, e_lat, n;
        string         rq;
        bit            extra;
        fld  = instr[14:11];
        mref = (fld == 4'b0010) || (fld == 4'b0100) || (fld == 4'b0101) ||
               (fld == 4'b0110) || (fld == 4'b1101);
        ind  = mref && instr[15];
        dadr = instr[AW-1:0];
        mem[pc0] = instr;
        eadr  = ind ? mem[dadr][AW-1:0] : dadr;
        opnd  = mem[eadr];
        probe = mem[dadr];
        e_ac = ac0; e_l = l0; e_pc = pc0 + 1'b1; wr = 0; wval = '0;
        e_cyc = !mref ? 1 : (ind ? 3 : 2);
        e_lat = !mref ? 3 : (fld == 4'b0010) ? (ind ? 5 : 3) : (ind ? 7 : 5);
        case (fld)
            4'b0001: e_ac = instr[15] ? ~{8'h00, instr[7:0]} : {8'h00, instr[7:0]};
            4'b0010: e_pc = eadr;
            4'b0100: begin wr = 1; wval = ac0; end
            4'b0101: begin wr = 1; wval = ac0; e_ac = opnd; end
            4'b0110: begin
                wr = 1; wval = opnd + 16'd1;
                if (wval == 16'd0) e_pc = pc0 + 2'd2;
            end
            4'b1101: begin {carry, s} = {1'b0, ac0} + {1'b0, opnd}; e_ac = s; e_l = l0 ^ carry; end
            default: ;
        endcase
        rq = req_of(fld, instr[15]);

        @(negedge clk);
        load_en = 1; load_ac = ac0; load_link = l0; load_pc = pc0;
        @(negedge clk);
        load_en = 0;
        check("R11", "preset", {ac, link, 4'b0, pc}, {ac0, l0, 4'b0, pc0});

        step = 1;
        @(negedge clk); n = 1;
        step = 0;
        if (disturb) begin
            load_en = 1; load_ac = 16'o052525; load_link = ~l0; load_pc = 11'o1777; step = 1;
            @(negedge clk); n = 2;
            load_en = 0; step = 0;
        end
        while (!done && n < 40) begin
            @(negedge clk); n++;
        end
        check("R12", "latency", n, e_lat);
        check(ind ? "R4" : rq, "cycles", cycles, e_cyc);
        check(rq, "ac", ac, e_ac);
        check(rq, "link", link, e_l);
        check(rq, "pc", pc, e_pc);
        if (wr) check(rq, "mem word", mem[eadr], wval);
        else    check(rq, "no write", mem[dadr], probe);
        @(negedge clk);
        check("R12", "done pulse width", done, 1'b0);
        if (disturb) begin
            extra = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (done || busy) extra = 1;
            end
            check("R11", "no restart while busy", extra, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "reset regs", {ac, link, 4'b0, pc}, '0);
        check("R1", "reset status", {busy, done, cycles}, '0);

        // Directed corners.
        run(16'o004000, 16'o012345, 1'b1, 11'o0100, 0);   // R2 zero
        run(16'o004377, 16'o012345, 1'b0, 11'o0100, 0);   // R2 max
        run(16'o104000, 16'o012345, 1'b1, 11'o0100, 0);   // R3 -> 0177777
        run(16'o104001, 16'o012345, 1'b0, 11'o0100, 0);   // R3 -> 0177776
        run(16'o010110, 16'o012345, 1'b1, 11'o0100, 0);   // R5 direct
        mem[11'o0110] = 16'o000120;
        run(16'o110110, 16'o012345, 1'b1, 11'o0100, 0);   // R5 indirect R4
        mem[11'o0101] = 16'o0;
        run(16'o020101, 16'o000001, 1'b1, 11'o0100, 0);   // R6 direct
        mem[11'o0101] = 16'o000102; mem[11'o0102] = 16'o0;
        run(16'o120101, 16'o177777, 1'b1, 11'o0100, 0);   // R6 indirect
        mem[11'o0101] = 16'o0;
        run(16'o024101, 16'o000002, 1'b1, 11'o0100, 0);   // R7
        mem[11'o0101] = 16'o177777;
        run(16'o030101, 16'o000002, 1'b0, 11'o0100, 0);   // R8 skip on zero
        mem[11'o0101] = 16'o0;
        run(16'o030101, 16'o000002, 1'b0, 11'o0100, 0);   // R8 no skip
        mem[11'o0101] = 16'o000001;
        run(16'o064101, 16'o177777, 1'b1, 11'o0100, 0);   // R9 carry flips link
        run(16'o064101, 16'o000000, 1'b1, 11'o0100, 0);   // R9 no carry
        run(16'o000101, 16'o004321, 1'b1, 11'o0100, 0);   // R10 no-op
        run(16'o064101, 16'o000007, 1'b0, 11'o0100, 1);   // R11 busy disturb
        run(16'o004055, 16'o000007, 1'b0, 11'o0100, 1);   // R11 busy disturb

        // Constrained random words.
        for (int k = 0; k < 80; k++) begin
            logic [3:0] flds [8];
            logic [3:0] f;
            logic [AW-1:0] da, tg, p0;
            logic [15:0] data, ins;
            bit indf;
            flds = '{4'b0001, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b1101, 4'b0000, 4'b1111};
            f    = flds[$urandom_range(0, 7)];
            indf = $urandom_range(0, 1) == 1;
            da   = AW'(512 + $urandom_range(0, 511));
            tg   = AW'(1024 + $urandom_range(0, 1023));
            p0   = AW'($urandom_range(0, 255));
            data = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            if (f == 4'b0001) ins = {indf, f, 3'b000, 8'($urandom)};
            else              ins = {indf, f, da};
            if (indf) begin
                mem[da] = {5'b0, tg};
                mem[tg] = data;
            end else begin
                mem[da] = data;
            end
            run(ins, 16'($urandom), 1'($urandom), p0, $urandom_range(0, 4) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule